// File: doc/BRIEF.md
# Host-to-DMA Word Staging FIFO

This block sits between a 16-bit host and one DMA channel. The host loads a transfer length and a channel descriptor, which holds the word count and the destination address. It then raises a transfer-active flag and streams data words into a shallow FIFO through a data port. The DMA side is only asked to drain once a whole group of four words is waiting. This keeps every burst aligned on a four-word boundary.

Each word the DMA side takes is handed out in arrival order together with its destination address. The address then steps by two bytes, and both the channel count and the remaining length decrement. When the remaining length runs out, the active flag drops by itself and later host words are refused. The DMA engine and the destination memory are outside this block.

Top module: `dreq_bridge`

## Requirements
- R1: After reset, fillCount, full, dmaReq, active, remLen, chCount and dmaAddr are all zero.
- R2: A hostWr pulse while active is low leaves the FIFO untouched.
- R3: The full output is high exactly when fillCount equals the depth (8 by default). A hostWr while full is dropped. A drain makes full low again.
- R4: dmaReq rises on the edge of an accepted host write that leaves fillCount at a nonzero multiple of four (4 or 8). It stays high until a drain leaves the FIFO empty or brings chCount to zero.
- R5: A drain happens on a dmaAck edge while fillCount is nonzero and chCount is nonzero. The drain consumes the word shown on dmaData, which is always the oldest stored word. The remaining words move up one place, so words leave in write order.
- R6: Every drain raises dmaAddr by 2 and lowers chCount by 1. It also lowers remLen by 1, and remLen never goes below zero.
- R7: A dmaAck while the FIFO is empty or chCount is zero changes nothing.
- R8: The drain that takes remLen from 1 to 0 also clears active. This clear wins over an actSet in the same cycle.
- R9: A host write and a drain in the same cycle leave fillCount unchanged. The new word lands behind the shifted contents.
- R10: lenWr loads remLen from lenData. chLoad loads chCount and dmaAddr from chCountIn and chAddrIn. actSet sets active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host data-port write strobe |
| hostData | input | 16 | Host data word |
| lenWr | input | 1 | Load remaining length |
| lenData | input | 16 | Remaining length value |
| actSet | input | 1 | Set the transfer-active flag |
| chLoad | input | 1 | Load channel count and destination address |
| chCountIn | input | 24 | Channel word count |
| chAddrIn | input | 32 | Channel destination byte address |
| dmaAck | input | 1 | DMA side takes the head word |
| active | output | 1 | Transfer-active flag |
| full | output | 1 | FIFO full flag |
| fillCount | output | 4 | Words held in the FIFO |
| remLen | output | 16 | Remaining length |
| dmaReq | output | 1 | DMA request |
| dmaData | output | 16 | Head word of the FIFO |
| dmaAddr | output | 32 | Destination address of the head word |
| chCount | output | 24 | Channel words left |

## Verification
The bench goes after the request threshold. It checks that the request stays low after three words, rises at four, and falls only when the FIFO empties; a design that compared against the fill count before the write would request one word late. It fills to eight and pushes a ninth word that must be dropped; a design that did not stop at full would overwrite the head or wrap the count. It also checks a write and a drain in the same cycle, where the wrong write slot would corrupt the order the scoreboard expects. Finally, it drains until both counts reach zero and then acks again; a design that kept draining would move the address and lose the three words left behind, which are later checked in order after a new descriptor is loaded.

// File: rtl/dreq_bridge_pkg.sv
package dreq_bridge_pkg;
  typedef struct packed {
    logic push;    // store hostData at the tail
    logic pop;     // hand the head word to the DMA side
    logic decRem;  // count one word off the remaining length
  } dreqStrobes_t;
endpackage

// File: rtl/dreq_bridge_datapath.sv
module dreq_bridge_datapath
  import dreq_bridge_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int LENW  = 16,
  parameter int CNTW  = 24,
  parameter int AW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  dreqStrobes_t    strb,
  input  logic [DW-1:0]   hostData,
  input  logic            lenWr,
  input  logic [LENW-1:0] lenData,
  input  logic            chLoad,
  input  logic [CNTW-1:0] chCountIn,
  input  logic [AW-1:0]   chAddrIn,
  output logic [CW-1:0]   fillCount,
  output logic            full,
  output logic [LENW-1:0] remLen,
  output logic [CNTW-1:0] chCount,
  output logic [AW-1:0]   dmaAddr,
  output logic [DW-1:0]   dmaData
);
  localparam int STEP = DW / 8;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [DW-1:0] slot [DEPTH];
  logic [CW-1:0] wrPos;

  // The tail slot moves up by one when the head leaves in the same cycle.
  assign wrPos = strb.pop ? fillCount - CW'(1) : fillCount;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [CW-1:0] IDX = CW'(i);
    logic [DW-1:0] above;
    if (i < DEPTH - 1) begin : g_mid
      assign above = slot[i + 1];
    end else begin : g_top
      assign above = '0;
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slot[i] <= '0;
      end else if (strb.push && wrPos == IDX) begin
        slot[i] <= hostData;
      end else if (strb.pop) begin
        slot[i] <= above;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCount <= '0;
    end else begin
      fillCount <= fillCount + CW'(strb.push) - CW'(strb.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remLen <= '0;
    end else if (lenWr) begin
      remLen <= lenData;
    end else if (strb.decRem && remLen != '0) begin
      remLen <= remLen - LENW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chCount <= '0;
      dmaAddr <= '0;
    end else if (chLoad) begin
      chCount <= chCountIn;
      dmaAddr <= chAddrIn;
    end else if (strb.pop) begin
      chCount <= chCount - CNTW'(1);
      dmaAddr <= dmaAddr + AW'(STEP);
    end
  end

  assign full    = (fillCount == DEPTH_C);
  assign dmaData = slot[0];
endmodule

// File: rtl/dreq_bridge_ctrl.sv
module dreq_bridge_ctrl
  import dreq_bridge_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int GROUP = 4,
  parameter int LENW  = 16,
  parameter int CNTW  = 24,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hostWr,
  input  logic            dmaAck,
  input  logic            actSet,
  input  logic [CW-1:0]   fillCount,
  input  logic            full,
  input  logic [LENW-1:0] remLen,
  input  logic [CNTW-1:0] chCount,
  output dreqStrobes_t    strb,
  output logic            active,
  output logic            dmaReq
);
  localparam logic [CW-1:0] GROUP_C = CW'(GROUP);

  logic [CW-1:0] nextFill;
  logic          lastWord;
  logic          chEnds;
  logic          groupReady;
  logic          reqDrop;

  always_comb begin
    strb        = '0;
    strb.push   = hostWr && active && !full;
    strb.pop    = dmaAck && fillCount != '0 && chCount != '0;
    strb.decRem = strb.pop;
  end

  assign nextFill   = fillCount + CW'(strb.push) - CW'(strb.pop);
  assign lastWord   = strb.pop && remLen == LENW'(1);
  assign chEnds     = strb.pop && chCount == CNTW'(1);
  assign groupReady = strb.push && nextFill != '0 && (nextFill % GROUP_C) == '0;
  assign reqDrop    = (strb.pop && nextFill == '0) || chEnds;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
    end else if (lastWord) begin
      active <= 1'b0;
    end else if (actSet) begin
      active <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaReq <= 1'b0;
    end else if (reqDrop) begin
      dmaReq <= 1'b0;
    end else if (groupReady) begin
      dmaReq <= 1'b1;
    end
  end
endmodule

// File: rtl/dreq_bridge.sv
module dreq_bridge
  import dreq_bridge_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int GROUP = 4,
  parameter int DW    = 16,
  parameter int LENW  = 16,
  parameter int CNTW  = 24,
  parameter int AW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hostWr,
  input  logic [DW-1:0]   hostData,
  input  logic            lenWr,
  input  logic [LENW-1:0] lenData,
  input  logic            actSet,
  input  logic            chLoad,
  input  logic [CNTW-1:0] chCountIn,
  input  logic [AW-1:0]   chAddrIn,
  input  logic            dmaAck,
  output logic            active,
  output logic            full,
  output logic [CW-1:0]   fillCount,
  output logic [LENW-1:0] remLen,
  output logic            dmaReq,
  output logic [DW-1:0]   dmaData,
  output logic [AW-1:0]   dmaAddr,
  output logic [CNTW-1:0] chCount
);
  dreqStrobes_t strb;

  dreq_bridge_ctrl #(
    .DEPTH(DEPTH), .GROUP(GROUP), .LENW(LENW), .CNTW(CNTW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .dmaAck(dmaAck),
    .actSet(actSet), .fillCount(fillCount), .full(full),
    .remLen(remLen), .chCount(chCount), .strb(strb),
    .active(active), .dmaReq(dmaReq)
  );

  dreq_bridge_datapath #(
    .DEPTH(DEPTH), .DW(DW), .LENW(LENW), .CNTW(CNTW), .AW(AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostData(hostData),
    .lenWr(lenWr), .lenData(lenData), .chLoad(chLoad),
    .chCountIn(chCountIn), .chAddrIn(chAddrIn),
    .fillCount(fillCount), .full(full), .remLen(remLen),
    .chCount(chCount), .dmaAddr(dmaAddr), .dmaData(dmaData)
  );
endmodule

// File: rtl/dreq_bridge_checker.sv
module dreq_bridge_checker #(
  parameter int DEPTH = 8,
  parameter int GROUP = 4,
  parameter int LENW  = 16,
  parameter int CNTW  = 24,
  parameter int AW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            hostWr,
  input logic            dmaAck,
  input logic            lenWr,
  input logic            chLoad,
  input logic            active,
  input logic            full,
  input logic [CW-1:0]   fillCount,
  input logic [LENW-1:0] remLen,
  input logic            dmaReq,
  input logic [AW-1:0]   dmaAddr,
  input logic [CNTW-1:0] chCount
);
  logic drainOk;
  assign drainOk = dmaAck && fillCount != '0 && chCount != '0;

  // R3
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CW'(DEPTH));

  // R3
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (full && hostWr && !dmaAck) |=> $stable(fillCount));

  // R2
  p_idle_ignore_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!active && hostWr && !dmaAck) |=> $stable(fillCount));

  // R4
  p_req_group_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaReq) |-> (fillCount != '0 && (fillCount % CW'(GROUP)) == '0));

  // R6
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (drainOk && !chLoad) |=> dmaAddr == $past(dmaAddr) + AW'(2));

  // R7
  p_dead_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dmaAck && !drainOk && !chLoad && !hostWr) |=> ($stable(dmaAddr) && $stable(fillCount)));

  // R8
  p_auto_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (drainOk && remLen == LENW'(1) && !lenWr) |=> (!active && remLen == '0));

  // R9
  p_both_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (drainOk && hostWr && active && !full) |=> $stable(fillCount));
endmodule

bind dreq_bridge dreq_bridge_checker #(
  .DEPTH(DEPTH), .GROUP(GROUP), .LENW(LENW), .CNTW(CNTW), .AW(AW)
) u_chk (
  .clk(clk), .rstN(rstN), .hostWr(hostWr), .dmaAck(dmaAck),
  .lenWr(lenWr), .chLoad(chLoad), .active(active), .full(full),
  .fillCount(fillCount), .remLen(remLen), .dmaReq(dmaReq),
  .dmaAddr(dmaAddr), .chCount(chCount)
);

// File: tb/dreq_bridge_bench.sv
module dreq_bridge_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0;
  logic [15:0] hostData = '0;
  logic        lenWr = 1'b0;
  logic [15:0] lenData = '0;
  logic        actSet = 1'b0;
  logic        chLoad = 1'b0;
  logic [23:0] chCountIn = '0;
  logic [31:0] chAddrIn = '0;
  logic        dmaAck = 1'b0;
  logic        active, full, dmaReq;
  logic [3:0]  fillCount;
  logic [15:0] remLen, dmaData;
  logic [31:0] dmaAddr;
  logic [23:0] chCount;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [15:0] expQ[$];
  int          mCount;
  bit          mActive, mReq;
  int          mRem, mCh;
  logic [31:0] mAddr;

  always #5 clk = ~clk;

  dreq_bridge u_dreq_bridge (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostData(hostData),
    .lenWr(lenWr), .lenData(lenData), .actSet(actSet), .chLoad(chLoad),
    .chCountIn(chCountIn), .chAddrIn(chAddrIn), .dmaAck(dmaAck),
    .active(active), .full(full), .fillCount(fillCount), .remLen(remLen),
    .dmaReq(dmaReq), .dmaData(dmaData), .dmaAddr(dmaAddr), .chCount(chCount)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic chkState(string req);
    chk(req, "fillCount", 32'(fillCount), 32'(mCount));
    chk(req, "full", 32'(full), 32'(mCount == 8));
    chk(req, "dmaReq", 32'(dmaReq), 32'(mReq));
    chk(req, "active", 32'(active), 32'(mActive));
    chk(req, "remLen", 32'(remLen), 32'(mRem));
    chk(req, "chCount", 32'(chCount), 32'(mCh));
    chk(req, "dmaAddr", dmaAddr, mAddr);
  endtask

  // One cycle: optional host write and/or DMA ack; model updated from the spec.
  task automatic step(string req, bit wr, logic [15:0] d, bit ack);
    bit push, pop;
    push = wr && mActive && mCount < 8;
    pop  = ack && mCount > 0 && mCh > 0;
    if (pop) begin
      // R5 scoreboard: head word must be the oldest accepted word
      chk("R5", "dmaData", 32'(dmaData), 32'(expQ[0]));
    end
    hostWr = wr; hostData = d; dmaAck = ack;
    @(posedge clk);
    @(negedge clk);
    hostWr = 1'b0; dmaAck = 1'b0;
    if (pop) begin
      void'(expQ.pop_front());
      mCh--; mAddr += 2;
      if (mRem > 0) mRem--;
      if (mRem == 0) mActive = 0;
    end
    if (push) expQ.push_back(d);
    mCount = mCount + int'(push) - int'(pop);
    if ((pop && mCount == 0) || (pop && mCh == 0)) mReq = 0;
    else if (push && mCount != 0 && mCount % 4 == 0) mReq = 1;
    chkState(req);
  endtask

  task automatic setup(int len, int cnt, logic [31:0] addr);
    lenWr = 1'b1; lenData = 16'(len);
    chLoad = 1'b1; chCountIn = 24'(cnt); chAddrIn = addr;
    actSet = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lenWr = 1'b0; chLoad = 1'b0; actSet = 1'b0;
    mRem = len; mCh = cnt; mAddr = addr; mActive = 1;
    chkState("R10");
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    mCount = 0; mActive = 0; mReq = 0; mRem = 0; mCh = 0; mAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chkState("R1");

    step("R2", 1'b1, 16'hdead, 1'b0);             // inactive write ignored
    setup(10, 10, 32'h1000);

    for (int i = 0; i < 3; i++) step("R4", 1'b1, 16'h0a00 + 16'(i), 1'b0);
    step("R4", 1'b1, 16'h0a03, 1'b0);             // fourth word raises request
    for (int i = 0; i < 4; i++) step("R6", 1'b0, '0, 1'b1);
    step("R7", 1'b0, '0, 1'b1);                   // ack on empty FIFO

    for (int i = 0; i < 8; i++) step("R3", 1'b1, 16'hb000 + 16'(i), 1'b0);
    step("R3", 1'b1, 16'hbeef, 1'b0);             // write while full dropped
    step("R3", 1'b0, '0, 1'b1);                   // drain clears full
    step("R9", 1'b1, 16'hc001, 1'b1);             // write+drain together
    for (int i = 0; i < 4; i++) step("R8", 1'b0, '0, 1'b1);
    step("R7", 1'b0, '0, 1'b1);                   // chCount zero blocks drain
    step("R2", 1'b1, 16'hd00d, 1'b0);             // inactive again

    setup(3, 3, 32'h2000);
    for (int i = 0; i < 3; i++) step("R5", 1'b0, '0, 1'b1);
    chk("R8", "queueEmpty", 32'(expQ.size()), 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule